// File: doc/BRIEF.md
# Stepwise I2C Bus Master

This block is a single-master I2C controller that a host drives one bus step at a time. Each step is a one-cycle command strobe: start, repeated start, stop, write a byte, read a byte, or send the acknowledge bit. The block produces the SCL waveform from a programmable half-period divider. It drives SDA open-drain, where a 1 on an output means the line is released and a 0 means it is pulled low. It sets a shared completion flag that the host clears, and it keeps the slave's acknowledge level and the last received byte in status outputs.

The block does not form addresses. The host writes the first byte after a start as a 7-bit slave address followed by the direction bit, where 0 means the master transmits and 1 means it receives. It then keeps issuing byte and acknowledge steps. A transfer ends with a stop, which frees the bus, or with a repeated start, which keeps the bus claimed. There is one master on the bus, and slaves do not stretch the clock.

Top module: `i2c_cmd_master`

## Requirements
- R1: SCL changes level only at the end of a half-period of N system clocks, where N is `div_i` and a value of 0 acts as 1. It stays constant whenever no step is in progress.
- R2: A start, issued with both lines high, pulls SDA low N clocks after the accept edge and SCL low N clocks after that. A repeated start releases SDA at accept, raises SCL at N, pulls SDA low at 2N and drops SCL at 3N. A stop pulls SDA low at accept, raises SCL at N and releases SDA at 2N.
- R3: A write clocks out 9 SCL pulses. The first 8 carry `wdata_i` MSB first, and during the 9th SDA is released. SDA takes each new bit when SCL falls, and takes the first bit at accept. The level on `sda_i` at the 9th falling edge goes to `ack_stat_o` (0 = ACK, 1 = NACK).
- R4: A read clocks out 8 SCL pulses with SDA released. It samples `sda_i` at each falling edge, MSB first, and loads the byte into `rdata_o` at completion. `rdata_o` changes at no other time.
- R5: An acknowledge step gives one SCL pulse with SDA at the `ack_data_i` level captured at accept (0 = ACK, 1 = NACK). SDA is released when the step completes.
- R6: `busy_o` is high from the accept edge through the final edge of a step, so a step lasts 2N clocks for start, stop and acknowledge, 3N for repeated start, 18N for a write and 16N for a read. `irq_o` is set on the final edge and stays set until `irq_clr_i`. A set on the same edge wins over the clear.
- R7: A command strobe while `busy_o` is high has no effect on the step in progress and sets `wcol_o`. `wcol_o` stays set until `wcol_clr_i`, and a set on the same edge wins.
- R8: Strobes that arrive together while idle are resolved by priority: start, then repeated start, stop, write, read and acknowledge. The losing strobes are dropped without setting `wcol_o`.
- R9: After reset, SCL and SDA are released, `busy_o`, `irq_o`, `wcol_o` and `ack_stat_o` are 0, and `rdata_o` is 0.
- R10: While SCL is high, SDA changes only as part of a start, a repeated start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | System clocks per SCL half-period |
| cmd_start_i | input | 1 | Start strobe |
| cmd_rstart_i | input | 1 | Repeated start strobe |
| cmd_stop_i | input | 1 | Stop strobe |
| cmd_write_i | input | 1 | Write-byte strobe |
| cmd_read_i | input | 1 | Read-byte strobe |
| cmd_ack_i | input | 1 | Send-acknowledge strobe |
| wdata_i | input | 8 | Byte to send on a write |
| ack_data_i | input | 1 | Level to send on an acknowledge step |
| irq_clr_i | input | 1 | Clears the completion flag |
| wcol_clr_i | input | 1 | Clears the collision flag |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| busy_o | output | 1 | Step in progress |
| irq_o | output | 1 | Sticky step-complete flag |
| wcol_o | output | 1 | Sticky ignored-command flag |
| ack_stat_o | output | 1 | Acknowledge level seen after the last write |
| rdata_o | output | 8 | Last byte read |

## Verification
The bench runs full transfers through every step type at divider values of 0, 1, 3 and 5. The single-clock cases expose off-by-one errors in the half-period count, and the longer divisors expose a tick that fires early or late. The written bytes (0xA4, 0x5C, 0xA5, 0xFF, 0x00) and the read bytes (0x96, 0x3C, 0x01) have distinct bit patterns. These separate bit-order mistakes, a missing last shift and stuck data bits. Slaves that ACK and slaves that NACK, along with acknowledge steps at both levels, separate the sampled acknowledge from the driven one. A write strobed during a stop, and a start strobed together with a write, exercise the collision flag and the priority order.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_START, OP_RSTART, OP_STOP, OP_WRITE, OP_READ, OP_ACK
  } op_e;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FRAME_W = BYTE_W + 1;
endpackage

// File: rtl/i2c_baud_tick.sv
module i2c_baud_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // div of 0 behaves as 1
  assign tick_o  = en_i && (cnt_inc >= {1'b0, div_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
  import i2c_cmd_pkg::*;
(
  input  logic start_i,
  input  logic rstart_i,
  input  logic stop_i,
  input  logic write_i,
  input  logic read_i,
  input  logic ack_i,
  output op_e  op_o,
  output logic any_o
);
  assign any_o = start_i | rstart_i | stop_i | write_i | read_i | ack_i;

  always_comb begin
    if (start_i)       op_o = OP_START;
    else if (rstart_i) op_o = OP_RSTART;
    else if (stop_i)   op_o = OP_STOP;
    else if (write_i)  op_o = OP_WRITE;
    else if (read_i)   op_o = OP_READ;
    else if (ack_i)    op_o = OP_ACK;
    else               op_o = OP_IDLE;
  end
endmodule

// File: rtl/i2c_frame_shift.sv
module i2c_frame_shift #(
  parameter int unsigned SH_W  = 8,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SH_W-1:0]  load_bits_i,
  input  logic [LEN_W-1:0] load_len_i,
  input  logic             shift_i,
  input  logic             sda_i,
  output logic             next_bit_o,
  output logic             last_o,
  output logic [SH_W-2:0]  low_o
);
  logic [SH_W-1:0]  sh_q;
  logic [LEN_W-1:0] len_q;

  // sh_q holds the bits after the one on the line; samples enter at the bottom
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      len_q <= '0;
    end else if (load_i) begin
      sh_q  <= load_bits_i;
      len_q <= load_len_i;
    end else if (shift_i) begin
      sh_q  <= {sh_q[SH_W-2:0], sda_i};
      len_q <= len_q - 1'b1;
    end
  end

  assign next_bit_o = sh_q[SH_W-1];
  assign last_o     = (len_q == LEN_W'(1));
  assign low_o      = sh_q[SH_W-2:0];
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cmd_start_i,
  input  logic              cmd_rstart_i,
  input  logic              cmd_stop_i,
  input  logic              cmd_write_i,
  input  logic              cmd_read_i,
  input  logic              cmd_ack_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ack_data_i,
  input  logic              irq_clr_i,
  input  logic              wcol_clr_i,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              wcol_o,
  output logic              ack_stat_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned LEN_W = $clog2(FRAME_W + 1);

  op_e               op_q, cmd_op;
  logic              cmd_any, accept, tick, done, is_bits, cmd_bits;
  logic [1:0]        step_q;
  logic              scl_q, sda_q, busy_q, irq_q, wcol_q, ack_q;
  logic [BYTE_W-1:0] rdata_q;
  logic [FRAME_W-1:0] load_val;
  logic [LEN_W-1:0]  load_len;
  logic              sh_load, sh_shift, next_bit, last_bit;
  logic [BYTE_W-2:0] sh_low;

  i2c_cmd_decode u_dec (
    .start_i (cmd_start_i), .rstart_i(cmd_rstart_i), .stop_i(cmd_stop_i),
    .write_i (cmd_write_i), .read_i  (cmd_read_i),   .ack_i (cmd_ack_i),
    .op_o    (cmd_op),      .any_o   (cmd_any)
  );

  i2c_baud_tick #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .en_i(busy_q), .div_i, .tick_o(tick)
  );

  assign accept   = cmd_any && !busy_q;
  assign is_bits  = (op_q == OP_WRITE) || (op_q == OP_READ) || (op_q == OP_ACK);
  assign cmd_bits = (cmd_op == OP_WRITE) || (cmd_op == OP_READ) || (cmd_op == OP_ACK);

  always_comb begin
    load_val = '1;
    load_len = '0;
    case (cmd_op)
      OP_WRITE: begin load_val = {wdata_i, 1'b1};            load_len = LEN_W'(FRAME_W); end
      OP_READ:  begin load_val = '1;                          load_len = LEN_W'(BYTE_W);  end
      OP_ACK:   begin load_val = {ack_data_i, {BYTE_W{1'b1}}}; load_len = LEN_W'(1);      end
      default: ;
    endcase
  end

  assign sh_load  = accept && cmd_bits;
  assign sh_shift = busy_q && tick && is_bits && scl_q;

  i2c_frame_shift #(.SH_W(BYTE_W), .LEN_W(LEN_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i     (sh_load),
    .load_bits_i(load_val[FRAME_W-2:0]),
    .load_len_i (load_len),
    .shift_i    (sh_shift),
    .sda_i,
    .next_bit_o (next_bit),
    .last_o     (last_bit),
    .low_o      (sh_low)
  );

  always_comb begin
    done = 1'b0;
    if (busy_q && tick) begin
      case (op_q)
        OP_START:  done = (step_q == 2'd1);
        OP_RSTART: done = (step_q == 2'd2);
        OP_STOP:   done = (step_q == 2'd1);
        OP_WRITE, OP_READ, OP_ACK: done = scl_q && last_bit;
        default:   done = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      step_q  <= '0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      busy_q  <= 1'b0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else if (accept) begin
      op_q   <= cmd_op;
      step_q <= '0;
      busy_q <= 1'b1;
      case (cmd_op)
        OP_RSTART: sda_q <= 1'b1;
        OP_STOP:   sda_q <= 1'b0;
        OP_WRITE, OP_READ, OP_ACK: sda_q <= load_val[FRAME_W-1];
        default: ;
      endcase
    end else if (busy_q && tick) begin
      step_q <= step_q + 1'b1;
      case (op_q)
        OP_START:
          if (step_q == 2'd0) sda_q <= 1'b0;
          else                scl_q <= 1'b0;
        OP_RSTART:
          case (step_q)
            2'd0:    scl_q <= 1'b1;
            2'd1:    sda_q <= 1'b0;
            default: scl_q <= 1'b0;
          endcase
        OP_STOP:
          if (step_q == 2'd0) scl_q <= 1'b1;
          else                sda_q <= 1'b1;
        OP_WRITE, OP_READ, OP_ACK:
          if (!scl_q) scl_q <= 1'b1;
          else begin
            scl_q <= 1'b0;
            sda_q <= last_bit ? 1'b1 : next_bit;
          end
        default: ;
      endcase
      if (done) begin
        busy_q <= 1'b0;
        op_q   <= OP_IDLE;
        if (op_q == OP_WRITE) ack_q   <= sda_i;
        if (op_q == OP_READ)  rdata_q <= {sh_low, sda_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      if (done)           irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
      if (cmd_any && busy_q) wcol_q <= 1'b1;
      else if (wcol_clr_i)   wcol_q <= 1'b0;
    end
  end

  assign scl_o      = scl_q;
  assign sda_o      = sda_q;
  assign busy_o     = busy_q;
  assign irq_o      = irq_q;
  assign wcol_o     = wcol_q;
  assign ack_stat_o = ack_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk
  import i2c_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_o,
  input logic       sda_o,
  input logic       busy_o,
  input logic       irq_o,
  input logic       wcol_o,
  input logic [7:0] rdata_o,
  input op_e        op_q,
  input logic       tick,
  input logic       cmd_any
);
  logic ctl_op, rd_busy;
  assign ctl_op  = (op_q == OP_START) || (op_q == OP_RSTART) || (op_q == OP_STOP);
  assign rd_busy = busy_o && (op_q == OP_READ);

  AST_SCL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o != $past(scl_o)) |-> $past(tick)); // R1
  AST_SCL_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(scl_o)); // R1
  AST_SDA_HIGH_CTL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |-> $past(ctl_op)); // R10
  AST_IRQ_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> irq_o); // R6
  AST_WCOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_any) |=> wcol_o); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_busy |=> $stable(rdata_o)); // R4
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk_i, .rst_ni, .scl_o, .sda_o, .busy_o, .irq_o, .wcol_o, .rdata_o,
  .op_q(op_q), .tick(tick), .cmd_any(cmd_any)
);

// File: tb/i2c_cmd_master_tb.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0] div = 16'd3;
  logic st = 0, rs = 0, sp = 0, wr = 0, rd = 0, ak = 0;
  logic [7:0] wdata = '0;
  logic ack_data = 1'b0, irq_clr = 1'b0, wcol_clr = 1'b0;
  logic slv_line = 1'b1;
  logic sda_line;
  logic scl_o, sda_o, busy_o, irq_o, wcol_o, ack_stat_o;
  logic [7:0] rdata_o;

  always #10 clk_i = ~clk_i;
  assign sda_line = sda_o & slv_line;

  i2c_cmd_master #(.DIV_W(16)) dut_i (
    .clk_i, .rst_ni, .div_i(div),
    .cmd_start_i(st), .cmd_rstart_i(rs), .cmd_stop_i(sp),
    .cmd_write_i(wr), .cmd_read_i(rd), .cmd_ack_i(ak),
    .wdata_i(wdata), .ack_data_i(ack_data), .irq_clr_i(irq_clr), .wcol_clr_i(wcol_clr),
    .sda_i(sda_line), .scl_o, .sda_o, .busy_o, .irq_o, .wcol_o, .ack_stat_o, .rdata_o
  );

  int total = 0, bad = 0;
  // reference model: queue of half-period actions {scl, sda, sample, final}
  logic m_scl = 1, m_sda = 1, m_busy = 0, m_irq = 0, m_wcol = 0, m_ack = 0;
  logic [7:0] m_rdata = '0;
  int m_cnt = 0, m_kind = 0, m_bi = 0, m_samp = 0;
  logic [3:0] m_q[$];
  logic [8:0] slv_pat = 9'h1FF;
  logic ack_seen = 1'b1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input int k);
    logic [8:0] v;
    int n;
    m_q.delete();
    m_cnt = 0; m_busy = 1; m_kind = k; m_bi = 0; m_samp = 0;
    case (k)
      1: begin m_q.push_back(4'b1000); m_q.push_back(4'b0001); end
      2: begin m_sda = 1; m_q.push_back(4'b1100); m_q.push_back(4'b1000); m_q.push_back(4'b0001); end
      3: begin m_sda = 0; m_q.push_back(4'b1000); m_q.push_back(4'b1101); end
      default: begin
        if (k == 4)      begin v = {wdata, 1'b1}; n = 9; end
        else if (k == 5) begin v = 9'h1FF; n = 8; end
        else             begin v = {ack_data, 8'hFF}; n = 1; end
        m_sda = v[8];
        for (int i = 0; i < n; i++) begin
          logic nb;
          nb = (i == n - 1) ? 1'b1 : v[7 - i];
          m_q.push_back({1'b1, v[8 - i], 2'b00});
          m_q.push_back({1'b0, nb, 1'b1, (i == n - 1)});
        end
      end
    endcase
  endtask

  task automatic model_adv();
    logic any, bb, fin, smp;
    logic [3:0] a;
    int k;
    bb = m_busy; fin = 0; smp = 0;
    any = st | rs | sp | wr | rd | ak;
    if (m_busy) begin
      if (m_cnt + 1 >= int'(div)) begin
        a = m_q.pop_front();
        m_cnt = 0;
        if (a[1]) begin
          smp = m_sda & slv_line;
          m_samp = (m_samp << 1) | int'(smp);
          m_bi++;
        end
        m_scl = a[3]; m_sda = a[2]; fin = a[0];
      end else m_cnt++;
    end
    if (fin) begin
      if (m_kind == 4) m_ack = smp;
      if (m_kind == 5) m_rdata = m_samp[7:0];
      m_busy = 0;
      m_irq = 1;
    end else if (irq_clr) m_irq = 0;
    if (any && bb) m_wcol = 1;
    else if (wcol_clr) m_wcol = 0;
    if (any && !bb) begin
      k = st ? 1 : rs ? 2 : sp ? 3 : wr ? 4 : rd ? 5 : 6;
      launch(k);
    end
  endtask

  task automatic tick_clk();
    model_adv();
    @(posedge clk_i);
    @(negedge clk_i);
    check(scl_o === m_scl, "R1", "scl_o", scl_o, m_scl);
    check(sda_o === m_sda, "R10", "sda_o", sda_o, m_sda);
    check(busy_o === m_busy, "R6", "busy_o", busy_o, m_busy);
    check(irq_o === m_irq, "R6", "irq_o", irq_o, m_irq);
    check(wcol_o === m_wcol, "R7", "wcol_o", wcol_o, m_wcol);
    check(ack_stat_o === m_ack, "R3", "ack_stat_o", ack_stat_o, m_ack);
    check(rdata_o === m_rdata, "R4", "rdata_o", rdata_o, m_rdata);
    if (m_busy && m_kind == 6 && scl_o) ack_seen = sda_o;
    slv_line = (m_busy && m_kind >= 4) ? slv_pat[8 - m_bi] : 1'b1;
    {st, rs, sp, wr, rd, ak} = '0;
    irq_clr = 0; wcol_clr = 0;
  endtask

  // mask order {start, rstart, stop, write, read, ack}; span = edges from accept to completion
  task automatic do_cmd(input logic [5:0] m, output int span);
    int n;
    {st, rs, sp, wr, rd, ak} = m;
    tick_clk();
    n = 0;
    while (m_busy && n < 100000) begin tick_clk(); n++; end
    span = n;
    irq_clr = 1;
    tick_clk();
  endtask

  function automatic int hp();
    return (div == 0) ? 1 : int'(div);
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL R6 watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sp_n;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(scl_o === 1 && sda_o === 1, "R9", "lines released", {scl_o, sda_o}, 3);
    check(busy_o === 0 && irq_o === 0 && wcol_o === 0 && ack_stat_o === 0, "R9", "flags", {busy_o, irq_o, wcol_o, ack_stat_o}, 0);
    check(rdata_o === 8'h00, "R9", "rdata_o", rdata_o, 0);
    rst_ni = 1;
    repeat (2) tick_clk();

    div = 16'd3;
    do_cmd(6'b100000, sp_n); check(sp_n == 2 * hp(), "R2", "start span", sp_n, 2 * hp());
    slv_pat = {8'hFF, 1'b0}; wdata = 8'hA4;
    do_cmd(6'b000100, sp_n); check(sp_n == 18 * hp(), "R6", "write span", sp_n, 18 * hp());
    check(ack_stat_o === 1'b0, "R3", "ACK seen", ack_stat_o, 0);
    slv_pat = 9'h1FF; wdata = 8'h5C;
    do_cmd(6'b000100, sp_n); check(ack_stat_o === 1'b1, "R3", "NACK seen", ack_stat_o, 1);
    do_cmd(6'b010000, sp_n); check(sp_n == 3 * hp(), "R2", "rstart span", sp_n, 3 * hp());
    slv_pat = {8'hFF, 1'b0}; wdata = 8'hA5;
    do_cmd(6'b000100, sp_n);
    slv_pat = {8'h96, 1'b1};
    do_cmd(6'b000010, sp_n); check(sp_n == 16 * hp(), "R4", "read span", sp_n, 16 * hp());
    check(rdata_o === 8'h96, "R4", "read byte", rdata_o, 8'h96);
    slv_pat = 9'h1FF; ack_data = 0;
    do_cmd(6'b000001, sp_n); check(ack_seen === 1'b0, "R5", "ack level", ack_seen, 0);
    check(sda_o === 1'b1, "R5", "sda released after ack", sda_o, 1);
    slv_pat = {8'h3C, 1'b1};
    do_cmd(6'b000010, sp_n); check(rdata_o === 8'h3C, "R4", "read byte", rdata_o, 8'h3C);
    slv_pat = 9'h1FF; ack_data = 1;
    do_cmd(6'b000001, sp_n); check(ack_seen === 1'b1, "R5", "nack level", ack_seen, 1);
    // R7: write strobed during a stop is ignored
    sp = 1; tick_clk();
    wr = 1; wdata = 8'h00; tick_clk();
    while (m_busy) tick_clk();
    check(wcol_o === 1'b1, "R7", "collision flag", wcol_o, 1);
    check(scl_o === 1 && sda_o === 1 && busy_o === 0, "R7", "bus free after stop", {scl_o, sda_o, busy_o}, 6);
    wcol_clr = 1; irq_clr = 1; tick_clk();
    check(wcol_o === 1'b0, "R7", "collision cleared", wcol_o, 0);

    // R8 priority with N=1 (div 0)
    div = 16'd0;
    do_cmd(6'b100100, sp_n); check(sp_n == 2, "R8", "start wins span", sp_n, 2);
    check(wcol_o === 1'b0, "R8", "no collision", wcol_o, 0);
    slv_pat = 9'h1FF; wdata = 8'hFF;
    do_cmd(6'b000100, sp_n); check(ack_stat_o === 1'b1, "R3", "NACK N=1", ack_stat_o, 1);
    div = 16'd1; slv_pat = {8'h01, 1'b1};
    do_cmd(6'b000010, sp_n); check(rdata_o === 8'h01, "R4", "read byte N=1", rdata_o, 8'h01);
    slv_pat = 9'h1FF; ack_data = 0;
    do_cmd(6'b000001, sp_n); check(sp_n == 2, "R5", "ack span", sp_n, 2);
    do_cmd(6'b001000, sp_n); check(sp_n == 2, "R2", "stop span", sp_n, 2);

    div = 16'd5;
    do_cmd(6'b100000, sp_n);
    slv_pat = {8'hFF, 1'b0}; wdata = 8'h00;
    do_cmd(6'b000100, sp_n); check(ack_stat_o === 1'b0, "R3", "ACK N=5", ack_stat_o, 0);
    slv_pat = 9'h1FF;
    do_cmd(6'b001000, sp_n); check(sp_n == 2 * hp(), "R2", "stop span N=5", sp_n, 2 * hp());
    // R6 irq holds until cleared
    sp_n = 0;
    {st} = 1; tick_clk();
    while (m_busy) tick_clk();
    repeat (4) tick_clk();
    check(irq_o === 1'b1, "R6", "irq sticky", irq_o, 1);
    irq_clr = 1; tick_clk();
    check(irq_o === 1'b0, "R6", "irq cleared", irq_o, 0);
    do_cmd(6'b001000, sp_n);
    repeat (3) tick_clk();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule